// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

The block decides which of five software localities (numbered 0 to 4) owns a shared command interface at any moment. Each locality sees its own 4 KB address window, selected by address bits [14:12]. Each window holds one 8-bit control register and one data port. A locality asks for the interface by writing the request bit of its control register. The owning locality gives the interface up by writing the active bit. The arbiter keeps the set of outstanding requests and the current owner. When nobody owns the interface it grants the highest-numbered waiting locality, and it pulses an event output whenever ownership moves.

Reads and writes arrive on a simple single-cycle register port. Read data is combinational. Accesses to the data port of a window pass through to the downstream command path only when that window's locality is the owner. Everything else is absorbed. Downstream logic can follow ownership directly through the owner outputs.

Top module: `loc_arbiter`

## Requirements
- R1: A read of any in-range locality's control register (window offset 0x000) always returns bit 7 = 1. Bits 6, 4, 3 and 0 always read 0.
- R2: Bit 5 of a control register reads 1 only in the register of the current owner. owner_vld_o and owner_o report the owner.
- R3: When no locality owns the interface and at least one request is pending, ownership is granted on the next clock edge. A request written at edge E is therefore the owner from edge E+1 on.
- R4: Among several pending requests, the highest-numbered locality is granted.
- R5: Writing a value with bit 5 (0x20) set to the owner's control register releases ownership at that write's clock edge.
- R6: A request write (bit 1, 0x02) from the locality that already owns the interface is ignored. A release write from a non-owning locality is ignored.
- R7: Bit 2 reads 1 in the owner's register while some other locality has a request pending. Bit 1 reads 1 in a locality's own register while that locality's request is pending.
- R8: loc_change_o is high for exactly one cycle after every clock edge at which the owner changes, whether by release or by grant.
- R9: A data-port access (window offset 0x024) from the owner drives dp_wr_o or dp_rd_o, and the read returns dp_rdata_i. The same access from a non-owner is dropped, and its read returns 0xFF.
- R10: Accesses to localities 5 to 7, or to unmapped offsets, read 0xFF and have no effect on any state.
- R11: If a request write lands at the same edge as a grant, it is not lost. A request from the locality being granted is absorbed by the grant and does not stay pending.
- R12: After reset no locality owns the interface, no request is pending and loc_change_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 15 | Byte address; bits [14:12] select the locality |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| dp_wr_o | output | 1 | Forwarded data-port write strobe |
| dp_rd_o | output | 1 | Forwarded data-port read strobe |
| dp_wdata_o | output | 8 | Forwarded write data |
| dp_rdata_i | input | 8 | Downstream read data |
| owner_vld_o | output | 1 | Some locality owns the interface |
| owner_o | output | 3 | Owning locality number |
| loc_change_o | output | 1 | One-cycle ownership-change event |

## Verification
The grant and a new request write can land on the same clock edge. The bench provokes this with back-to-back request writes into an idle arbiter. The first write makes a request pending, and the second arrives exactly at the edge that grants the first. In one run the second write comes from the locality being granted. That request must vanish: its bit 1 reads 0, and a later release leaves the interface idle. In another run the second write comes from a different locality. That request must survive: the owner's bit 2 reads 1, the second locality's bit 1 reads 1, and it is granted after the owner releases.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_CTRL = 2'd1,
    WIN_DATA = 2'd2
  } win_kind_e;

  // control register bit positions
  localparam int unsigned VLD_BIT = 7;
  localparam int unsigned ACT_BIT = 5;
  localparam int unsigned OTH_BIT = 2;
  localparam int unsigned REQ_BIT = 1;

  localparam logic [7:0] RD_DEAD = 8'hFF;
endpackage

// File: rtl/loc_win_decode.sv
module loc_win_decode
  import loc_arb_pkg::*;
#(
  parameter int          NUM_LOC  = 5,
  parameter int          LW       = 3,
  parameter int          ADDR_W   = 15,
  parameter int          WIN_BITS = 12,
  parameter int unsigned CTRL_OFS = 'h000,
  parameter int unsigned DATA_OFS = 'h024
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_kind_e         kind_o,
  output logic [LW-1:0]     loc_o,
  output logic [NUM_LOC-1:0] loc_oh_o
);
  localparam int FW = ADDR_W - WIN_BITS;

  logic [FW-1:0]       loc_full;
  logic [WIN_BITS-1:0] ofs;
  logic                loc_ok;

  assign loc_full = addr_i[ADDR_W-1:WIN_BITS];
  assign ofs      = addr_i[WIN_BITS-1:0];
  assign loc_ok   = loc_full < FW'(NUM_LOC);
  assign loc_o    = LW'(loc_full);

  always_comb begin
    kind_o = WIN_NONE;
    if (loc_ok) begin
      if (ofs == WIN_BITS'(CTRL_OFS))      kind_o = WIN_CTRL;
      else if (ofs == WIN_BITS'(DATA_OFS)) kind_o = WIN_DATA;
    end
  end

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_oh
    assign loc_oh_o[i] = loc_ok && (loc_full == FW'(i));
  end
endmodule

// File: rtl/loc_grant.sv
module loc_grant #(
  parameter int NUM_LOC = 5,
  parameter int LW      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LOC-1:0] req_set_i,
  input  logic [NUM_LOC-1:0] rel_req_i,
  output logic [NUM_LOC-1:0] pend_o,
  output logic [NUM_LOC-1:0] own_oh_o,
  output logic               own_vld_o,
  output logic [LW-1:0]      own_o,
  output logic               change_o
);
  logic [NUM_LOC-1:0] pend_q, pend_d, set_eff, own_oh, grant_oh;
  logic               own_vld_q, own_vld_d, change_q, change_d, rel_hit;
  logic [LW-1:0]      own_q, own_d, hi_idx;
  logic               any_pend;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_own
    assign own_oh[i]   = own_vld_q && (own_q == LW'(i));
    assign grant_oh[i] = !own_vld_q && any_pend && (hi_idx == LW'(i));
  end

  // highest-numbered pending request wins
  always_comb begin
    hi_idx   = '0;
    any_pend = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pend_q[i]) begin
        hi_idx   = LW'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign set_eff = req_set_i & ~own_oh;
  assign rel_hit = |(rel_req_i & own_oh);

  always_comb begin
    // grant clear beats a same-edge set from the granted locality
    pend_d    = (pend_q | set_eff) & ~grant_oh;
    own_vld_d = own_vld_q;
    own_d     = own_q;
    change_d  = 1'b0;
    if (own_vld_q) begin
      if (rel_hit) begin
        own_vld_d = 1'b0;
        change_d  = 1'b1;
      end
    end else if (any_pend) begin
      own_vld_d = 1'b1;
      own_d     = hi_idx;
      change_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      own_vld_q <= 1'b0;
      own_q     <= '0;
      change_q  <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      own_vld_q <= own_vld_d;
      own_q     <= own_d;
      change_q  <= change_d;
    end
  end

  assign pend_o    = pend_q;
  assign own_oh_o  = own_oh;
  assign own_vld_o = own_vld_q;
  assign own_o     = own_q;
  assign change_o  = change_q;

  // R3
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_vld_q && (|pend_q)) |=> own_vld_q);

  // R4
  top_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_vld_q && (|pend_q)) |=>
      (($past(pend_q) >> own_q) == {{(NUM_LOC-1){1'b0}}, 1'b1}));

  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_q && rel_hit) |=> !own_vld_q);

  // R6
  hold_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_q && !rel_hit) |=> (own_vld_q && $stable(own_q)));

  // R11
  no_self_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_vld_q |-> !pend_q[own_q]);

  // R8
  change_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_q |-> ((own_vld_q != $past(own_vld_q)) || (own_q != $past(own_q))));

  // R8
  change_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_q != $past(own_vld_q)) |-> change_q);
endmodule

// File: rtl/loc_rd_mux.sv
module loc_rd_mux
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int DW      = 8
) (
  input  win_kind_e          kind_i,
  input  logic [NUM_LOC-1:0] loc_oh_i,
  input  logic [NUM_LOC-1:0] own_oh_i,
  input  logic [NUM_LOC-1:0] pend_i,
  input  logic [DW-1:0]      dp_rdata_i,
  output logic [DW-1:0]      rdata_o
);
  logic is_owner, self_pend, other_pend;

  assign is_owner   = |(loc_oh_i & own_oh_i);
  assign self_pend  = |(loc_oh_i & pend_i);
  assign other_pend = |(~loc_oh_i & pend_i);

  always_comb begin
    rdata_o = DW'(RD_DEAD);
    unique case (kind_i)
      WIN_CTRL: begin
        rdata_o          = '0;
        rdata_o[VLD_BIT] = 1'b1;
        rdata_o[ACT_BIT] = is_owner;
        rdata_o[OTH_BIT] = is_owner && other_pend;
        rdata_o[REQ_BIT] = self_pend;
      end
      WIN_DATA: if (is_owner) rdata_o = dp_rdata_i;
      default:  ;
    endcase
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int ADDR_W   = 15,
  parameter int WIN_BITS = 12,
  parameter int DW       = 8,
  parameter int LW       = $clog2(NUM_LOC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              dp_wr_o,
  output logic              dp_rd_o,
  output logic [DW-1:0]     dp_wdata_o,
  input  logic [DW-1:0]     dp_rdata_i,
  output logic              owner_vld_o,
  output logic [LW-1:0]     owner_o,
  output logic              loc_change_o
);
  win_kind_e          kind;
  logic [LW-1:0]      dec_loc;
  logic [NUM_LOC-1:0] loc_oh, own_oh, pend, req_set, rel_req;
  logic               ctrl_wr, data_hit, own_match;

  loc_win_decode #(
    .NUM_LOC (NUM_LOC),
    .LW      (LW),
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS)
  ) u_dec (
    .addr_i  (bus_addr_i),
    .kind_o  (kind),
    .loc_o   (dec_loc),
    .loc_oh_o(loc_oh)
  );

  assign ctrl_wr = bus_req_i && bus_we_i && (kind == WIN_CTRL);
  assign req_set = {NUM_LOC{ctrl_wr && bus_wdata_i[REQ_BIT]}} & loc_oh;
  assign rel_req = {NUM_LOC{ctrl_wr && bus_wdata_i[ACT_BIT]}} & loc_oh;

  loc_grant #(
    .NUM_LOC(NUM_LOC),
    .LW     (LW)
  ) u_grant (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_set_i(req_set),
    .rel_req_i(rel_req),
    .pend_o   (pend),
    .own_oh_o (own_oh),
    .own_vld_o(owner_vld_o),
    .own_o    (owner_o),
    .change_o (loc_change_o)
  );

  loc_rd_mux #(
    .NUM_LOC(NUM_LOC),
    .DW     (DW)
  ) u_rd (
    .kind_i    (kind),
    .loc_oh_i  (loc_oh),
    .own_oh_i  (own_oh),
    .pend_i    (pend),
    .dp_rdata_i(dp_rdata_i),
    .rdata_o   (bus_rdata_o)
  );

  assign data_hit   = bus_req_i && (kind == WIN_DATA);
  assign own_match  = |(loc_oh & own_oh);
  assign dp_wr_o    = data_hit && bus_we_i && own_match;
  assign dp_rd_o    = data_hit && !bus_we_i && own_match;
  assign dp_wdata_o = bus_wdata_i;

  // R9
  dp_owner_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_wr_o || dp_rd_o) |-> (owner_vld_o && (owner_o == dec_loc)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!owner_vld_o && !loc_change_o));
endmodule

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, dp_wdata, dp_rdata = 8'h3C;
  logic        dp_wr, dp_rd, own_vld, chg;
  logic [2:0]  own;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5ns clk = ~clk;

  loc_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .dp_wr_o(dp_wr), .dp_rd_o(dp_rd), .dp_wdata_o(dp_wdata), .dp_rdata_i(dp_rdata),
    .owner_vld_o(own_vld), .owner_o(own), .loc_change_o(chg)
  );

  function automatic logic [14:0] ctl(int l); return 15'(l << 12); endfunction
  function automatic logic [14:0] dat(int l); return 15'((l << 12) | 'h24); endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [14:0] a, logic [7:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [14:0] a, output logic [7:0] d);
    req = 1; we = 0; addr = a;
    #1ns d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R12 owner_vld", own_vld, 0);
    check("R12 change", chg, 0);
    for (int l = 0; l < 5; l++) begin
      rd(ctl(l), v);
      check("R1/R12 idle ctrl", v, 8'h80);
    end
  endtask

  task automatic t_grant_idle;
    logic [7:0] v;
    wr(ctl(2), 8'h02);
    check("R3 not yet owner", own_vld, 0);
    idle(1);
    check("R3 owner_vld", own_vld, 1);
    check("R3 owner", own, 2);
    check("R8 grant event", chg, 1);
    idle(1);
    check("R8 event ends", chg, 0);
    rd(ctl(2), v); check("R2 owner ctrl", v, 8'hA0);
    rd(ctl(0), v); check("R2 other ctrl", v, 8'h80);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(ctl(2), 8'h02);
    idle(2);
    rd(ctl(2), v); check("R6 owner re-request", v, 8'hA0);
    wr(ctl(1), 8'h20);
    idle(2);
    check("R6 foreign release vld", own_vld, 1);
    check("R6 foreign release owner", own, 2);
    check("R6 no event", chg, 0);
  endtask

  task automatic t_flags_and_priority;
    logic [7:0] v;
    wr(ctl(0), 8'h02); wr(ctl(4), 8'h02); wr(ctl(1), 8'h02);
    idle(1);
    rd(ctl(2), v); check("R7 owner other-pending", v, 8'hA4);
    rd(ctl(4), v); check("R7 self pending", v, 8'h82);
    wr(ctl(2), 8'h20);
    check("R5 released", own_vld, 0);
    check("R8 release event", chg, 1);
    idle(1);
    check("R4 highest wins", own, 4);
    check("R4 owner_vld", own_vld, 1);
    check("R8 second event", chg, 1);
    idle(1);
    check("R8 event ends", chg, 0);
    wr(ctl(4), 8'h20); idle(1);
    check("R4 next is 1", own, 1);
    wr(ctl(1), 8'h20); idle(1);
    check("R4 next is 0", own, 0);
    rd(ctl(0), v); check("R7 no others", v, 8'hA0);
    wr(ctl(0), 8'h20); idle(2);
    check("R5 idle after last", own_vld, 0);
  endtask

  task automatic t_data;
    logic [7:0] v;
    wr(ctl(3), 8'h02); idle(1);
    check("R3 owner 3", own, 3);
    req = 1; we = 1; addr = dat(3); wdata = 8'h5A;
    #1ns;
    check("R9 owner write fwd", dp_wr, 1);
    check("R9 owner wdata", dp_wdata, 8'h5A);
    addr = dat(1);
    #1ns check("R9 foreign write drop", dp_wr, 0);
    @(negedge clk); req = 0; we = 0;
    req = 1; addr = dat(1);
    #1ns;
    check("R9 foreign read data", rdata, 8'hFF);
    check("R9 foreign read drop", dp_rd, 0);
    addr = dat(3);
    #1ns;
    check("R9 owner read data", rdata, 8'h3C);
    check("R9 owner read fwd", dp_rd, 1);
    @(negedge clk); req = 0;
  endtask

  task automatic t_out_of_range;
    logic [7:0] v;
    rd(ctl(5), v); check("R10 loc5 read", v, 8'hFF);
    rd(ctl(7), v); check("R10 loc7 read", v, 8'hFF);
    rd(15'h3008, v); check("R10 unmapped read", v, 8'hFF);
    wr(ctl(6), 8'h02);
    wr(15'h3008, 8'h20);
    req = 1; we = 1; addr = dat(5); wdata = 8'h11;
    #1ns check("R10 loc5 data drop", dp_wr, 0);
    @(negedge clk); req = 0; we = 0;
    idle(1);
    check("R10 owner kept", own, 3);
    check("R10 owner_vld kept", own_vld, 1);
    rd(ctl(3), v); check("R10 no pending created", v, 8'hA0);
    wr(ctl(3), 8'h20); idle(2);
    check("R10 idle", own_vld, 0);
  endtask

  task automatic t_same_edge;
    logic [7:0] v;
    wr(ctl(3), 8'h02); wr(ctl(3), 8'h02);
    check("R11 granted 3", own, 3);
    idle(1);
    rd(ctl(3), v); check("R11 self absorbed", v, 8'hA0);
    wr(ctl(3), 8'h20); idle(2);
    check("R11 no re-grant", own_vld, 0);
    wr(ctl(3), 8'h02); wr(ctl(1), 8'h02);
    check("R11 granted 3 again", own, 3);
    idle(1);
    rd(ctl(3), v); check("R11 other kept (owner)", v, 8'hA4);
    rd(ctl(1), v); check("R11 other kept (self)", v, 8'h82);
    wr(ctl(3), 8'h20); idle(1);
    check("R11 kept request granted", own, 1);
    wr(ctl(1), 8'h20); idle(2);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_grant_idle();
    t_ignored();
    t_flags_and_priority();
    t_data();
    t_out_of_range();
    t_same_edge();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule